// File: doc/BRIEF.md
# Double-Buffered Host Parallel Port

This block is a slave-only parallel port that carries 24-bit words between an 8-bit external host bus and a 24-bit processor-side bus. The host always masters the bus; the port only answers reads and writes. Each direction is a two-stage pipeline. In the host-to-processor direction the host fills three byte registers and the word then moves on its own into a processor-side receive register. In the processor-to-host direction the processor writes a transmit register and the word then moves on its own into three host-readable byte registers.

Each inner move takes one clock and fires only when the stage behind it is empty. A host data access in the same cycle holds the move back by one cycle, so the host access always takes effect first. Status flags can be polled on both sides. Per-direction enables gate the processor interrupt and DMA request outputs and a single host request output.

Top module: `host_port_dbuf`

## Requirements
- R1: After reset, a host read at address 0 returns 0x01 (bit 0 = host transmit bytes empty, bit 1 = host receive bytes full). The processor sees `cpu_hrdf_o`=0, `cpu_htde_o`=1 and `cpu_rdata_o`=0. `host_req_o` and all processor interrupt and request outputs are 0.
- R2: A host write to address 3 (the low byte) clears status bit 0. Address 1 holds the high byte and address 2 the middle byte. In the next clock with no host data access, the word {addr1,addr2,addr3} appears on `cpu_rdata_o`, `cpu_hrdf_o` rises and status bit 0 returns to 1.
- R3: While `cpu_hrdf_o`=1, a new host word waits: status bit 0 stays 0 and `cpu_rdata_o` keeps the old word. A `cpu_rd_i` pulse clears `cpu_hrdf_o`, and the waiting word moves one clock later.
- R4: A `cpu_wr_i` pulse loads the processor transmit register and clears `cpu_htde_o`. One clock later the word moves to the host receive bytes: status bit 1 sets and `cpu_htde_o` returns to 1. Host reads of addresses 1, 2 and 3 then return the high, middle and low bytes.
- R5: While status bit 1 is set, a new processor word waits in the transmit register with `cpu_htde_o`=0, and the host bytes keep the old word. A host read of address 3 clears bit 1, and the waiting word moves one clock after that.
- R6: Host writes and reads of addresses 1 and 2 change no flag. Bytes written there are latched and form part of the next word.
- R7: A host data access (read or write, address not 0) blocks both inner moves in that cycle. The move happens in the next cycle without such an access.
- R8: A `cpu_ctl_we_i` pulse stores `cpu_ctl_i`: bit 0 enables the receive interrupt, bit 1 the transmit interrupt, bit 2 the receive DMA request and bit 3 the transmit DMA request. Each output equals its enable AND `cpu_hrdf_o` (receive) or `cpu_htde_o` (transmit).
- R9: A host write to address 0 stores bit 0 (transmit request enable) and bit 1 (receive request enable). `host_req_o` = (enable0 AND status bit 0) OR (enable1 AND status bit 1).
- R10: Streams of words in both directions, paced by polling the flags, arrive in order with none lost or duplicated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| h_cs_i | input | 1 | Host chip select |
| h_we_i | input | 1 | Host write strobe |
| h_re_i | input | 1 | Host read strobe |
| h_addr_i | input | 2 | Host address: 0 status/control, 1 high, 2 middle, 3 low |
| h_wdata_i | input | 8 | Host write data |
| h_rdata_o | output | 8 | Host read data |
| host_req_o | output | 1 | Host request |
| cpu_wr_i | input | 1 | Processor write of the transmit register |
| cpu_wdata_i | input | 24 | Processor write data |
| cpu_rd_i | input | 1 | Processor read of the receive register |
| cpu_rdata_o | output | 24 | Processor receive register |
| cpu_ctl_we_i | input | 1 | Processor enable register write |
| cpu_ctl_i | input | 4 | Processor interrupt and DMA enables |
| cpu_hrdf_o | output | 1 | Processor receive register full |
| cpu_htde_o | output | 1 | Processor transmit register empty |
| cpu_rx_irq_o | output | 1 | Receive interrupt |
| cpu_tx_irq_o | output | 1 | Transmit interrupt |
| cpu_rx_dreq_o | output | 1 | Receive DMA request |
| cpu_tx_dreq_o | output | 1 | Transmit DMA request |

## Verification
The bench goes after the blocking corners. A second word sent while the far stage is still full must wait rather than overwrite. A design that ignored the empty check would overwrite an unread word or deliver it twice. A host data access that coincides with a pending move must delay the move by exactly one cycle; a design that moved anyway would hand over a half-updated word. High and middle byte accesses must not touch the flags, or a design would mark a word full or empty too early. Back-to-back streams in both directions, checked against queues, catch lost or repeated words.

// File: rtl/hpd_pkg.sv
package hpd_pkg;
  // bit 3..0 of the processor enable word
  typedef struct packed {
    logic tx_dreq_en;
    logic rx_dreq_en;
    logic tx_irq_en;
    logic rx_irq_en;
  } cpu_ctl_t;

  // bit 1..0 of the host enable word
  typedef struct packed {
    logic rx_req_en;
    logic tx_req_en;
  } host_ctl_t;
endpackage

// File: rtl/hpd_h2c.sv
module hpd_h2c #(
  parameter int BYTE_W = 8,
  parameter int NBYTES = 3,
  parameter int ADDR_W = 2
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             h_we_i,
  input  logic                             h_acc_i,
  input  logic [ADDR_W-1:0]                h_addr_i,
  input  logic [BYTE_W-1:0]                h_wdata_i,
  input  logic                             cpu_rd_i,
  output logic [NBYTES-1:0][BYTE_W-1:0]    hrx_o,
  output logic                             hrdf_o,
  output logic                             txde_o
);
  logic [NBYTES-1:0][BYTE_W-1:0] tx_q, hrx_q;
  logic txde_q, hrdf_q, low_wr, xfer;

  // addr k+1 holds byte NBYTES-1-k; last address is the low byte
  for (genvar k = 0; k < NBYTES; k++) begin : g_tx_byte
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) tx_q[NBYTES-1-k] <= '0;
      else if (h_we_i && h_addr_i == ADDR_W'(k+1)) tx_q[NBYTES-1-k] <= h_wdata_i;
    end
  end

  assign low_wr = h_we_i && (h_addr_i == ADDR_W'(NBYTES));
  assign xfer   = !txde_q && !hrdf_q && !h_acc_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      txde_q <= 1'b1;
      hrdf_q <= 1'b0;
      hrx_q  <= '0;
    end else begin
      if (low_wr)    txde_q <= 1'b0;
      else if (xfer) txde_q <= 1'b1;
      if (xfer)          hrdf_q <= 1'b1;
      else if (cpu_rd_i) hrdf_q <= 1'b0;
      if (xfer) hrx_q <= tx_q;
    end
  end

  assign hrx_o  = hrx_q;
  assign hrdf_o = hrdf_q;
  assign txde_o = txde_q;

  // R3
  hrx_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hrdf_q && !cpu_rd_i |=> hrdf_q && $stable(hrx_q));
  // R7
  h2c_stall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    h_acc_i |=> !$rose(hrdf_q));
  // R2
  h2c_move_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hrdf_q) |-> txde_q && $past(!txde_q));
endmodule

// File: rtl/hpd_c2h.sv
module hpd_c2h #(
  parameter int BYTE_W = 8,
  parameter int NBYTES = 3,
  parameter int ADDR_W = 2
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             cpu_wr_i,
  input  logic [NBYTES*BYTE_W-1:0]         cpu_wdata_i,
  input  logic                             h_re_i,
  input  logic                             h_acc_i,
  input  logic [ADDR_W-1:0]                h_addr_i,
  output logic [NBYTES-1:0][BYTE_W-1:0]    rx_o,
  output logic                             rxdf_o,
  output logic                             htde_o
);
  logic [NBYTES-1:0][BYTE_W-1:0] htx_q, rx_q;
  logic htde_q, rxdf_q, low_rd, xfer;

  assign low_rd = h_re_i && (h_addr_i == ADDR_W'(NBYTES));
  assign xfer   = !htde_q && !rxdf_q && !h_acc_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      htx_q  <= '0;
      rx_q   <= '0;
      htde_q <= 1'b1;
      rxdf_q <= 1'b0;
    end else begin
      if (cpu_wr_i) htx_q <= cpu_wdata_i;
      if (cpu_wr_i)  htde_q <= 1'b0;
      else if (xfer) htde_q <= 1'b1;
      if (xfer)        rxdf_q <= 1'b1;
      else if (low_rd) rxdf_q <= 1'b0;
      if (xfer) rx_q <= htx_q;
    end
  end

  assign rx_o   = rx_q;
  assign rxdf_o = rxdf_q;
  assign htde_o = htde_q;

  // R5
  rx_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rxdf_q |=> $stable(rx_q));
  // R7
  c2h_stall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    h_acc_i |=> !$rose(rxdf_q));
  // R4
  c2h_move_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rxdf_q) |-> htde_q && $past(!htde_q));
endmodule

// File: rtl/hpd_hs.sv
module hpd_hs
  import hpd_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cpu_ctl_we_i,
  input  logic [3:0] cpu_ctl_i,
  input  logic       h_ctl_we_i,
  input  logic [1:0] h_ctl_i,
  input  logic       hrdf_i,
  input  logic       htde_i,
  input  logic       txde_i,
  input  logic       rxdf_i,
  output logic       host_req_o,
  output logic       rx_irq_o,
  output logic       tx_irq_o,
  output logic       rx_dreq_o,
  output logic       tx_dreq_o
);
  cpu_ctl_t  cctl_q;
  host_ctl_t hctl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cctl_q <= '0;
      hctl_q <= '0;
    end else begin
      if (cpu_ctl_we_i) cctl_q <= cpu_ctl_t'(cpu_ctl_i);
      if (h_ctl_we_i)   hctl_q <= host_ctl_t'(h_ctl_i);
    end
  end

  assign rx_irq_o   = cctl_q.rx_irq_en  & hrdf_i;
  assign tx_irq_o   = cctl_q.tx_irq_en  & htde_i;
  assign rx_dreq_o  = cctl_q.rx_dreq_en & hrdf_i;
  assign tx_dreq_o  = cctl_q.tx_dreq_en & htde_i;
  assign host_req_o = (hctl_q.tx_req_en & txde_i) | (hctl_q.rx_req_en & rxdf_i);
endmodule

// File: rtl/host_port_dbuf.sv
module host_port_dbuf #(
  parameter  int BYTE_W = 8,
  parameter  int NBYTES = 3,
  localparam int WORD_W = NBYTES * BYTE_W,
  localparam int ADDR_W = $clog2(NBYTES + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              h_cs_i,
  input  logic              h_we_i,
  input  logic              h_re_i,
  input  logic [ADDR_W-1:0] h_addr_i,
  input  logic [BYTE_W-1:0] h_wdata_i,
  output logic [BYTE_W-1:0] h_rdata_o,
  output logic              host_req_o,
  input  logic              cpu_wr_i,
  input  logic [WORD_W-1:0] cpu_wdata_i,
  input  logic              cpu_rd_i,
  output logic [WORD_W-1:0] cpu_rdata_o,
  input  logic              cpu_ctl_we_i,
  input  logic [3:0]        cpu_ctl_i,
  output logic              cpu_hrdf_o,
  output logic              cpu_htde_o,
  output logic              cpu_rx_irq_o,
  output logic              cpu_tx_irq_o,
  output logic              cpu_rx_dreq_o,
  output logic              cpu_tx_dreq_o
);
  logic h_wr, h_rd, h_data_acc, h_ctl_we;
  logic txde, rxdf, hrdf, htde;
  logic [NBYTES-1:0][BYTE_W-1:0] hrx, rx_w;
  logic [BYTE_W-1:0] rd_byte;

  assign h_wr       = h_cs_i & h_we_i;
  assign h_rd       = h_cs_i & h_re_i;
  assign h_data_acc = (h_wr | h_rd) & (h_addr_i != '0);
  assign h_ctl_we   = h_wr & (h_addr_i == '0);

  hpd_h2c #(.BYTE_W(BYTE_W), .NBYTES(NBYTES), .ADDR_W(ADDR_W)) i_h2c (
    .clk_i, .rst_ni,
    .h_we_i(h_wr), .h_acc_i(h_data_acc), .h_addr_i, .h_wdata_i,
    .cpu_rd_i, .hrx_o(hrx), .hrdf_o(hrdf), .txde_o(txde)
  );

  hpd_c2h #(.BYTE_W(BYTE_W), .NBYTES(NBYTES), .ADDR_W(ADDR_W)) i_c2h (
    .clk_i, .rst_ni,
    .cpu_wr_i, .cpu_wdata_i,
    .h_re_i(h_rd), .h_acc_i(h_data_acc), .h_addr_i,
    .rx_o(rx_w), .rxdf_o(rxdf), .htde_o(htde)
  );

  hpd_hs i_hs (
    .clk_i, .rst_ni,
    .cpu_ctl_we_i, .cpu_ctl_i,
    .h_ctl_we_i(h_ctl_we), .h_ctl_i(h_wdata_i[1:0]),
    .hrdf_i(hrdf), .htde_i(htde), .txde_i(txde), .rxdf_i(rxdf),
    .host_req_o,
    .rx_irq_o(cpu_rx_irq_o), .tx_irq_o(cpu_tx_irq_o),
    .rx_dreq_o(cpu_rx_dreq_o), .tx_dreq_o(cpu_tx_dreq_o)
  );

  always_comb begin
    rd_byte = '0;
    for (int k = 0; k < NBYTES; k++)
      if (h_addr_i == ADDR_W'(k+1)) rd_byte = rx_w[NBYTES-1-k];
  end

  assign h_rdata_o   = (h_addr_i == '0) ? {{(BYTE_W-2){1'b0}}, rxdf, txde} : rd_byte;
  assign cpu_rdata_o = hrx;
  assign cpu_hrdf_o  = hrdf;
  assign cpu_htde_o  = htde;

  // R2
  h_low_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    h_wr && h_addr_i == ADDR_W'(NBYTES) |=> !h_rdata_o[0] || h_addr_i != '0);
endmodule

// File: tb/test_host_port_dbuf.sv
`timescale 1ns/1ps
module test_host_port_dbuf;
  logic clk = 1'b0;
  logic rst_n;
  logic h_cs, h_we, h_re;
  logic [1:0] h_addr;
  logic [7:0] h_wdata;
  logic [7:0] h_rdata;
  logic host_req;
  logic cpu_wr;
  logic [23:0] cpu_wdata;
  logic man_rd, mon_rd, cpu_rd;
  logic [23:0] cpu_rdata;
  logic cpu_ctl_we;
  logic [3:0] cpu_ctl;
  logic hrdf, htde, rx_irq, tx_irq, rx_dreq, tx_dreq;

  int n_cmp = 0, n_bad = 0;
  logic [23:0] h2c_q[$];
  logic [23:0] c2h_q[$];
  bit mon_en = 1'b0;

  always #2.5 clk = ~clk;
  assign cpu_rd = man_rd | mon_rd;

  host_port_dbuf i_host_port_dbuf (
    .clk_i(clk), .rst_ni(rst_n),
    .h_cs_i(h_cs), .h_we_i(h_we), .h_re_i(h_re), .h_addr_i(h_addr),
    .h_wdata_i(h_wdata), .h_rdata_o(h_rdata), .host_req_o(host_req),
    .cpu_wr_i(cpu_wr), .cpu_wdata_i(cpu_wdata), .cpu_rd_i(cpu_rd),
    .cpu_rdata_o(cpu_rdata), .cpu_ctl_we_i(cpu_ctl_we), .cpu_ctl_i(cpu_ctl),
    .cpu_hrdf_o(hrdf), .cpu_htde_o(htde),
    .cpu_rx_irq_o(rx_irq), .cpu_tx_irq_o(tx_irq),
    .cpu_rx_dreq_o(rx_dreq), .cpu_tx_dreq_o(tx_dreq)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic host_wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk);
    h_cs = 1; h_we = 1; h_re = 0; h_addr = a; h_wdata = d;
  endtask

  task automatic host_rd(logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    h_cs = 1; h_we = 0; h_re = 1; h_addr = a;
    #1 d = h_rdata;
  endtask

  task automatic host_idle();
    @(negedge clk);
    h_cs = 0; h_we = 0; h_re = 0; h_addr = 0;
    #1;
  endtask

  task automatic cpu_put(logic [23:0] w);
    @(negedge clk);
    cpu_wr = 1; cpu_wdata = w;
    @(negedge clk);
    cpu_wr = 0;
    #1;
  endtask

  task automatic cpu_ctl_set(logic [3:0] v);
    @(negedge clk);
    cpu_ctl_we = 1; cpu_ctl = v;
    @(negedge clk);
    cpu_ctl_we = 0;
    #1;
  endtask

  task automatic cpu_pop();
    @(negedge clk);
    man_rd = 1;
    @(negedge clk);
    man_rd = 0;
    #1;
  endtask

  // driver: host-to-processor word, expected item queued
  task automatic host_send(logic [23:0] w);
    do host_idle(); while (!h_rdata[0]);
    host_wr(1, w[23:16]);
    host_wr(2, w[15:8]);
    host_wr(3, w[7:0]);
    h2c_q.push_back(w);
    host_idle();
  endtask

  // driver: processor-to-host word
  task automatic cpu_send(logic [23:0] w);
    while (!htde) @(negedge clk);
    c2h_q.push_back(w);
    cpu_put(w);
  endtask

  // monitor: host side reader for processor-to-host stream
  task automatic host_recv();
    logic [7:0] b1, b2, b3;
    do host_idle(); while (!h_rdata[1]);
    host_rd(1, b1);
    host_rd(2, b2);
    host_rd(3, b3);
    host_idle();
    if (c2h_q.size() == 0) chk("R10 c2h queue underflow", 32'(1), 32'(0));
    else chk("R10 c2h word", {8'h0, b1, b2, b3}, {8'h0, c2h_q.pop_front()});
  endtask

  // monitor: processor side reader for host-to-processor stream
  initial begin
    mon_rd = 0;
    forever begin
      @(negedge clk);
      mon_rd = 0;
      if (mon_en && hrdf) begin
        if (h2c_q.size() == 0) chk("R10 h2c queue underflow", 32'(1), 32'(0));
        else chk("R10 h2c word", {8'h0, cpu_rdata}, {8'h0, h2c_q.pop_front()});
        mon_rd = 1;
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] b;
    rst_n = 0; h_cs = 0; h_we = 0; h_re = 0; h_addr = 0; h_wdata = 0;
    cpu_wr = 0; cpu_wdata = 0; man_rd = 0; cpu_ctl_we = 0; cpu_ctl = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    // R1 reset state
    chk("R1 status", 32'(h_rdata), 32'h01);
    chk("R1 hrdf", 32'(hrdf), 32'(0));
    chk("R1 htde", 32'(htde), 32'(1));
    chk("R1 cpu_rdata", 32'(cpu_rdata), 32'(0));
    chk("R1 outs", {27'h0, host_req, rx_irq, tx_irq, rx_dreq, tx_dreq}, 32'(0));

    // R2 host word to processor
    host_wr(1, 8'hA1); host_wr(2, 8'hB2); host_wr(3, 8'hC3);
    host_idle();
    chk("R2 txde cleared", 32'(h_rdata[0]), 32'(0));
    chk("R2 hrdf not yet", 32'(hrdf), 32'(0));
    host_idle();
    chk("R2 hrdf set", 32'(hrdf), 32'(1));
    chk("R2 txde set", 32'(h_rdata[0]), 32'(1));
    chk("R2 word", 32'(cpu_rdata), 32'hA1B2C3);

    // R8 enables
    cpu_ctl_set(4'hF);
    chk("R8 all enabled", {28'h0, rx_irq, tx_irq, rx_dreq, tx_dreq}, 32'hF);
    cpu_ctl_set(4'b0101);
    chk("R8 rx only", {28'h0, rx_irq, tx_irq, rx_dreq, tx_dreq}, 32'b1010);

    // R3 second word waits behind full receive register
    host_wr(1, 8'hD4); host_wr(2, 8'hE5); host_wr(3, 8'hF6);
    host_idle(); host_idle(); host_idle();
    chk("R3 txde held", 32'(h_rdata[0]), 32'(0));
    chk("R3 hrdf held", 32'(hrdf), 32'(1));
    chk("R3 old word", 32'(cpu_rdata), 32'hA1B2C3);
    cpu_pop();
    chk("R3 hrdf cleared", 32'(hrdf), 32'(0));
    @(negedge clk); #1;
    chk("R3 new word", 32'(cpu_rdata), 32'hD4E5F6);
    chk("R3 hrdf again", 32'(hrdf), 32'(1));
    chk("R3 txde again", 32'(h_rdata[0]), 32'(1));
    cpu_pop();
    chk("R8 rx irq drops", {30'h0, rx_irq, rx_dreq}, 32'(0));

    // R6 high/mid writes leave flags alone
    host_wr(1, 8'h11); host_wr(2, 8'h22);
    host_idle(); host_idle();
    chk("R6 status after hi/mid", 32'(h_rdata), 32'h01);
    chk("R6 hrdf after hi/mid", 32'(hrdf), 32'(0));
    // R7 data access stalls the move
    host_wr(3, 8'h33);
    host_rd(1, b);
    chk("R7 no move yet", 32'(hrdf), 32'(0));
    host_idle();
    chk("R7 stalled", 32'(hrdf), 32'(0));
    host_idle();
    chk("R7 moved", 32'(hrdf), 32'(1));
    chk("R6 latched bytes", 32'(cpu_rdata), 32'h112233);
    cpu_pop();

    // R9 host request
    host_wr(0, 8'h01);
    host_idle();
    chk("R9 tx req", 32'(host_req), 32'(1));
    host_wr(0, 8'h02);
    host_idle();
    chk("R9 rx req idle", 32'(host_req), 32'(0));

    // R4 processor word to host
    cpu_put(24'h123456);
    chk("R4 htde cleared", 32'(htde), 32'(0));
    chk("R4 rxdf not yet", 32'(h_rdata[1]), 32'(0));
    @(negedge clk); #1;
    chk("R4 htde set", 32'(htde), 32'(1));
    chk("R4 rxdf set", 32'(h_rdata[1]), 32'(1));
    chk("R9 rx req", 32'(host_req), 32'(1));

    // R5 next word waits
    cpu_put(24'h789ABC);
    @(negedge clk); @(negedge clk); #1;
    chk("R5 htde held", 32'(htde), 32'(0));
    host_rd(1, b); chk("R4 high", 32'(b), 32'h12);
    host_rd(2, b); chk("R4 mid", 32'(b), 32'h34);
    host_idle();
    chk("R6 rxdf after hi/mid read", 32'(h_rdata[1]), 32'(1));
    host_rd(3, b); chk("R4 low", 32'(b), 32'h56);
    host_idle();
    chk("R5 rxdf cleared", 32'(h_rdata[1]), 32'(0));
    chk("R5 still waiting", 32'(htde), 32'(0));
    host_idle();
    chk("R5 rxdf again", 32'(h_rdata[1]), 32'(1));
    chk("R5 htde again", 32'(htde), 32'(1));
    host_rd(1, b); chk("R5 high", 32'(b), 32'h78);
    host_rd(2, b); chk("R5 mid", 32'(b), 32'h9A);
    host_rd(3, b); chk("R5 low", 32'(b), 32'hBC);
    host_idle();

    // R10 streams
    mon_en = 1;
    for (int i = 0; i < 6; i++) host_send(24'h100000 + 24'(i) * 24'h010203);
    repeat (6) @(negedge clk);
    chk("R10 h2c drained", 32'(h2c_q.size()), 32'(0));
    mon_en = 0;
    fork
      begin
        for (int i = 0; i < 6; i++) cpu_send(24'h800000 + 24'(i) * 24'h030507);
      end
      begin
        for (int i = 0; i < 6; i++) host_recv();
      end
    join
    chk("R10 c2h drained", 32'(c2h_q.size()), 32'(0));

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule